// File: doc/BRIEF.md
# ARINC 429 Receive Bit Decoder

This block turns three per-sample comparator flags into 32-bit words. The flags are one, zero and null, taken from a bipolar return-to-zero line at ten samples per bit. It derives its own sample tick from the master clock: the divide ratio is 10 in the fast setting and 80 in the slow one. Each flag goes through its own ten-sample history. From those histories the decoder qualifies pulse widths, checks the spacing between bit starts and counts the quiet line between words. Only a word whose every bit passes those rules reaches the output.

A word is accepted only after a word gap has armed the decoder. Once the thirty-second bit is closed by its trailing null, the assembled word appears on the output together with a one-clock end-of-sequence pulse. Any timing violation throws the partial word away. The decoder then stays idle until a fresh gap has been seen. Level detection ahead of the block, and label filtering or host access after it, belong to other blocks.

Top module: `a429_rx_bitdec`

## Requirements
- R1: A sample tick occurs once every 10 master clocks when `rate_slow` is 0 and once every 80 when it is 1. Each tick shifts one sample of each flag into its ten-sample history.
- R2: A bit starts when the three newest samples all show the same polarity (one or zero) and the fourth newest sample does not. A pulse shorter than three samples never starts a bit, so the word carrying it is lost.
- R3: A sample in which `smp_one` and `smp_zero` are both high counts as neither one, zero nor null. A null sample counts only when neither polarity flag is high.
- R4: After each bit start, three consecutive null samples must arrive before the next bit start. If another start comes first, the word is discarded.
- R5: Within a word, bit starts must be 8 to 12 samples apart, inclusive. A start outside that window, or 13 samples passing without one, discards the word.
- R6: While idle, a gap null is a tick where both the three newest and the three oldest null samples are set. Each gap null increments a gap count, and any non-null sample clears it. The third gap null arms the decoder. Bits that arrive before arming are ignored.
- R7: When the 32nd bit's trailing null qualifies, `eos_o` is high for exactly one clock and `word_o` takes the word. The first received bit is at `word_o[0]`, a one pulse gives 1 and a zero pulse gives 0.
- R8: Reset leaves `eos_o` low, `word_o` zero and the decoder idle. After a discarded word, no word is accepted until a new gap has armed the decoder.
- R9: `word_o` keeps its value until the next `eos_o`. Discarded words leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_slow | input | 1 | 0: sample every 10 clocks, 1: every 80 clocks |
| smp_one | input | 1 | Comparator flag: line at the one level |
| smp_zero | input | 1 | Comparator flag: line at the zero level |
| smp_null | input | 1 | Comparator flag: line at the null level |
| word_o | output | 32 | Last accepted word, first bit at index 0 |
| eos_o | output | 1 | One-clock pulse when a word is accepted |

## Verification
A corrupted flag history, spacing count or bit counter inside this block cannot be seen directly. It shows at the ports as a word that fails to produce `eos_o`, as a pulse where none is due, or as a wrong bit value in `word_o`. In each case it becomes visible by the end of the word in flight, at most about 32 bit times later. A wrong divide ratio shows on the first word sent at that rate, because every bit then appears too long or too short. A gap counter that arms too early or too late shows on the word that follows a gap placed exactly at the arming threshold.

// File: rtl/a429_rx_bitdec.sv
module a429_rx_bitdec #(
  parameter int DIV_LO = 10,
  parameter int DIV_HI = 80,
  parameter int HIST   = 10,
  parameter int RUN    = 3,
  parameter int SP_MIN = 8,
  parameter int SP_MAX = 12,
  parameter int GAP_N  = 3,
  parameter int WBITS  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rate_slow,
  input  logic             smp_one,
  input  logic             smp_zero,
  input  logic             smp_null,
  output logic [WBITS-1:0] word_o,
  output logic             eos_o
);
  localparam int CW  = $clog2(DIV_HI);
  localparam int NBW = $clog2(WBITS);
  localparam int SPW = $clog2(SP_MAX + 2);
  localparam int GW  = $clog2(GAP_N + 1);

  typedef enum logic [1:0] {S_IDLE, S_BIT, S_NUL} st_t;

  st_t             st_q;
  logic [CW-1:0]   div_q;
  logic [HIST-1:0] h_one, h_zero, h_null;
  logic [HIST-1:0] h_one_n, h_zero_n, h_null_n;
  logic [SPW-1:0]  spc_q;
  logic [GW-1:0]   gap_q;
  logic [NBW-1:0]  nb_q;
  logic [WBITS-1:0] sh_q, sh_nx;
  logic            bit_q;
  logic            tick, one_start, zero_start, bit_start, null_run, gap_null;
  logic            sp_ok, late, last, fail, accept, arm;

  // sample tick
  wire [CW-1:0] lim = rate_slow ? CW'(DIV_HI - 1) : CW'(DIV_LO - 1);
  assign tick = div_q >= lim;

  always_ff @(posedge clk)
    if (!rst_n)    div_q <= '0;
    else if (tick) div_q <= '0;
    else           div_q <= div_q + 1'b1;

  // sample histories, newest at index 0
  wire s1 = smp_one & ~smp_zero;
  wire s0 = smp_zero & ~smp_one;
  wire sn = smp_null & ~smp_one & ~smp_zero;

  assign h_one_n  = {h_one[HIST-2:0], s1};
  assign h_zero_n = {h_zero[HIST-2:0], s0};
  assign h_null_n = {h_null[HIST-2:0], sn};

  assign one_start  = (&h_one_n[RUN-1:0]) & ~h_one_n[RUN];
  assign zero_start = (&h_zero_n[RUN-1:0]) & ~h_zero_n[RUN];
  assign bit_start  = one_start | zero_start;
  assign null_run   = &h_null_n[RUN-1:0];
  assign gap_null   = null_run & (&h_null_n[HIST-1:HIST-RUN]);

  assign sp_ok = (spc_q >= SPW'(SP_MIN)) && (spc_q <= SPW'(SP_MAX));
  assign late  = spc_q > SPW'(SP_MAX);
  assign last  = nb_q == NBW'(WBITS - 1);
  assign sh_nx = {bit_q, sh_q[WBITS-1:1]};

  always_comb begin
    fail   = 1'b0;
    accept = 1'b0;
    arm    = 1'b0;
    case (st_q)
      S_IDLE: arm = gap_null && (gap_q == GW'(GAP_N - 1));
      S_BIT:
        if (bit_start) fail = (nb_q != '0) && !sp_ok;
        else           fail = (nb_q != '0) && late;
      S_NUL:
        if (bit_start || late) fail = 1'b1;
        else                   accept = null_run;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      h_one  <= '0;
      h_zero <= '0;
      h_null <= '0;
      spc_q  <= '0;
      gap_q  <= '0;
      nb_q   <= '0;
      sh_q   <= '0;
      bit_q  <= 1'b0;
      word_o <= '0;
      eos_o  <= 1'b0;
    end else begin
      eos_o <= 1'b0;
      if (tick) begin
        h_one  <= h_one_n;
        h_zero <= h_zero_n;
        h_null <= h_null_n;
        if (spc_q <= SPW'(SP_MAX)) spc_q <= spc_q + 1'b1;
        if (fail) begin
          st_q  <= S_IDLE;
          gap_q <= '0;
          nb_q  <= '0;
        end else begin
          case (st_q)
            S_IDLE:
              if (!h_null_n[0]) gap_q <= '0;
              else if (arm) begin
                st_q  <= S_BIT;
                gap_q <= '0;
                nb_q  <= '0;
              end else if (gap_null) gap_q <= gap_q + 1'b1;
            S_BIT:
              if (bit_start) begin
                st_q  <= S_NUL;
                bit_q <= one_start;
                spc_q <= SPW'(1);
              end
            S_NUL:
              if (accept) begin
                sh_q <= sh_nx;
                if (last) begin
                  word_o <= sh_nx;
                  eos_o  <= 1'b1;
                  st_q   <= S_IDLE;
                  gap_q  <= '0;
                  nb_q   <= '0;
                end else begin
                  nb_q <= nb_q + 1'b1;
                  st_q <= S_BIT;
                end
              end
            default: st_q <= S_IDLE;
          endcase
        end
      end
    end
  end

  // R1: divider stays inside the slow range, end pulse only after a tick
  a_r1_div_range: assert property (@(posedge clk) disable iff (!rst_n)
    div_q <= CW'(DIV_HI - 1));
  a_r1_eos_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    eos_o |-> $past(tick));
  // R3: the three histories never claim the same sample twice
  a_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    ((h_one & h_zero) | (h_one & h_null) | (h_zero & h_null)) == '0);
  // R5: a later bit start is taken only inside the spacing window
  a_r5_window: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == S_BIT && st_q == S_NUL && $past(nb_q) != '0)
      |-> ($past(spc_q) >= SPW'(SP_MIN) && $past(spc_q) <= SPW'(SP_MAX)));
  // R6: leaving idle for reception needs the full gap count
  a_r6_arm: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == S_IDLE && st_q == S_BIT)
      |-> ($past(gap_q) == GW'(GAP_N - 1) && $past(tick)));
  // R7: end pulse lasts one clock
  a_r7_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    eos_o |=> !eos_o);
  // R9: output word moves only together with the end pulse
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !eos_o |-> $stable(word_o));
endmodule

// File: tb/sim_a429_rx_bitdec.sv
`timescale 1ns/1ps
module sim_a429_rx_bitdec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rate_slow = 1'b0;
  logic        smp_one = 1'b0, smp_zero = 1'b0, smp_null = 1'b0;
  logic [31:0] word_o;
  logic        eos_o;

  int          n_chk = 0, n_bad = 0, eos_n = 0, slot = 10;
  logic [31:0] last_w = '0;
  logic        done = 1'b0;

  a429_rx_bitdec u0 (.clk(clk), .rst_n(rst_n), .rate_slow(rate_slow),
    .smp_one(smp_one), .smp_zero(smp_zero), .smp_null(smp_null),
    .word_o(word_o), .eos_o(eos_o));

  always #2 clk = ~clk;

  always @(negedge clk)
    if (rst_n && eos_o) begin
      eos_n  <= eos_n + 1;
      last_w <= word_o;
    end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic expect_rx(input string r, input int en, input logic [31:0] ew);
    @(negedge clk);
    chk(r, 32'(eos_n), 32'(en));
    chk(r, last_w, ew);
  endtask

  task automatic put(input logic o, input logic z, input logic n);
    smp_one = o; smp_zero = z; smp_null = n;
    repeat (slot) @(negedge clk);
  endtask

  task automatic nulls(input int k);
    for (int i = 0; i < k; i++) put(1'b0, 1'b0, 1'b1);
  endtask

  // alt bit uses a 4-sample pulse and alt_len samples to the next start
  task automatic send(input logic [31:0] w, input int hi, input int len,
                      input int alt_i, input int alt_len, input int conf_i, input int gap);
    for (int b = 0; b < 32; b++) begin
      int l_b = (b == alt_i) ? alt_len : len;
      int h_b = (b == alt_i) ? 4 : hi;
      for (int s = 0; s < l_b; s++) begin
        if (s >= h_b)                         put(1'b0, 1'b0, 1'b1);
        else if (b == conf_i && (s == 2 || s == 3)) put(1'b1, 1'b1, 1'b0);
        else                                  put(w[b], ~w[b], 1'b0);
      end
    end
    nulls(gap);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk("R8 reset eos", 32'(eos_o), 32'd0);
    chk("R8 reset word", word_o, 32'd0);
    rst_n = 1'b1;
    nulls(40);
    chk("R8 idle no eos", 32'(eos_n), 32'd0);

    send(32'hA5C3_0F1E, 5, 10, -1, 0, -1, 40);
    expect_rx("R7 R1 nominal word", 1, 32'hA5C3_0F1E);
    send(32'h0000_0000, 3, 8, -1, 0, -1, 40);
    expect_rx("R2 R5 shortest pulse and spacing", 2, 32'h0000_0000);
    send(32'hFFFF_FFFF, 9, 12, -1, 0, -1, 40);
    expect_rx("R4 R5 longest spacing three nulls", 3, 32'hFFFF_FFFF);
    send(32'h8000_0001, 5, 10, 10, 7, -1, 40);
    expect_rx("R5 R9 spacing 7 discarded", 3, 32'hFFFF_FFFF);
    send(32'h8000_0001, 5, 10, 10, 13, -1, 40);
    expect_rx("R5 R9 spacing 13 discarded", 3, 32'hFFFF_FFFF);
    send(32'h1234_5678, 5, 10, 10, 8, -1, 40);
    expect_rx("R5 R8 spacing 8 after discard", 4, 32'h1234_5678);
    send(32'h0F0F_33CC, 5, 10, 20, 12, -1, 40);
    expect_rx("R5 spacing 12", 5, 32'h0F0F_33CC);
    send(32'h5555_AAAA, 2, 10, -1, 0, -1, 40);
    expect_rx("R2 two-sample pulses ignored", 5, 32'h0F0F_33CC);
    send(32'h6B6B_0101, 8, 10, -1, 0, -1, 40);
    expect_rx("R4 two trailing nulls discarded", 5, 32'h0F0F_33CC);
    send(32'h3C3C_9999, 5, 10, -1, 0, 5, 40);
    expect_rx("R3 conflicting samples discarded", 5, 32'h0F0F_33CC);
    send(32'h7E81_4242, 5, 10, -1, 0, -1, 7);
    expect_rx("R6 word before 12-null gap", 6, 32'h7E81_4242);
    send(32'h1818_E7E7, 5, 10, -1, 0, -1, 6);
    expect_rx("R6 word after exact gap", 7, 32'h1818_E7E7);
    send(32'h2468_ACE0, 5, 10, -1, 0, -1, 40);
    expect_rx("R6 word after short gap ignored", 7, 32'h1818_E7E7);
    send(32'h9BDF_1357, 5, 10, -1, 0, -1, 40);
    expect_rx("R6 R8 rearmed after long gap", 8, 32'h9BDF_1357);

    rate_slow = 1'b1;
    slot = 80;
    nulls(40);
    send(32'hC001_D00D, 5, 10, -1, 0, -1, 20);
    expect_rx("R1 slow rate word", 9, 32'hC001_D00D);
    finish_run();
  end

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule